// File: doc/BRIEF.md
# Flash Bank Erase and Program Sequencer

This block runs the full command protocol needed to rewrite one bank of a byte-wide flash device that reports progress through a status register. A single request selects the operation (erase or program) and the bank. The sequencer then drives the flash bus by itself until the job is finished.

For an erase, it writes the two-byte erase command to the bank base and polls status. For a program, it handles each byte in turn: a setup command, a fixed settle delay, the data byte, and a status poll. Each status poll is a read-status command followed by a read of the bank base. Polling stops when the ready bit appears, or gives up after a fixed number of attempts.

When the erase or program phase ends, the block clears the status register and puts the device back in read mode. It then reads the bank back byte by byte against the expected contents. Program data comes from an indexed byte source: the block presents a byte offset and takes the data byte back in the same cycle. The source is read once while programming and again while verifying. At the end, a one-cycle done pulse carries an overall error flag and a three-bit cause vector.

Top module: `flash_bank_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err`, `fl_we` and `fl_re` are low and `err_cause` is zero.
- R2: A request is taken only while idle. Kind and bank are latched at acceptance. `req_valid` while busy has no effect on the bank addressed or the operation performed.
- R3: An erase writes 0x20 and then 0xD0, both to the bank base address. The base address is the bank number times BANK_BYTES, and the bank number forms the upper address bits.
- R4: Each status poll writes 0x70 to the bank base and then reads the bank base. Bit 7 (0x80) of the read value means the operation is complete.
- R5: Each program byte at offset i writes 0x40 to base+i. It then leaves the bus idle for SETUP_WAIT_CYC cycles, writes the source byte for offset i to base+i, and polls status. Offsets run upward from 0 to BANK_BYTES-1.
- R6: After the erase or program phase, the block writes 0x50 and then, on the next cycle, 0xFF, both to the bank base.
- R7: If POLL_LIMIT consecutive polls all read bit 7 clear, the block sets `err_cause[0]` (timeout) and skips any remaining program bytes. It then goes straight to the 0x50/0xFF step.
- R8: A completed poll whose value has any of bits 5..3 (mask 0x38) set sets `err_cause[1]` (device fault), even when the verify pass succeeds.
- R9: Verify reads offsets 0 upward. An erase expects 0xFF at each offset; a program expects the source byte. The first mismatch sets `err_cause[2]` and ends the verify pass.
- R10: `done` is high for exactly one cycle at the end of each accepted request. `err` equals the OR of the `err_cause` bits. Both are held until the next request is accepted.
- R11: `fl_we` and `fl_re` are never high together. Every bus access addresses the latched bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request, taken when idle |
| req_prog | input | 1 | 1 = program, 0 = erase |
| req_bank | input | BANK_SEL_W | Bank number |
| src_addr | output | OFF_W | Byte offset for the program data source |
| src_data | input | 8 | Source byte for `src_addr`, same cycle |
| fl_addr | output | OFF_W+BANK_SEL_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe, data expected next cycle |
| fl_rdata | input | 8 | Flash read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Any error cause set |
| err_cause | output | 3 | [0] timeout, [1] device fault, [2] verify mismatch |

## Verification
The bench uses a 16-byte, four-bank configuration. It erases every bank, then programs every bank with three source patterns: all zero, alternating 0x55/0xAA, and an arithmetic mix. This shows that bank decoding and per-byte offsets are right and that no other bank is disturbed. A behavioural flash model with varied busy latencies flags any protocol violation: a misordered command, a short settle gap, an access outside the bank, or a reset not preceded by a clear. Faults are injected separately to tell the causes apart. A never-ready device must set only the timeout path and stop after the first program byte. A fault status bit with good data must set only the fault cause. A corrupted middle or last byte must end verification exactly at that offset. A request held during a busy program must leave its target bank untouched.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ERS_SETUP,
    S_ERS_CONF,
    S_PGM_SETUP,
    S_PGM_WAIT,
    S_PGM_DATA,
    S_POLL_CMD,
    S_POLL_RD,
    S_POLL_EVAL,
    S_CLR,
    S_RST,
    S_VER_RD,
    S_VER_EVAL,
    S_FINISH
  } seq_state_e;

  localparam logic [7:0] OP_ERS_SETUP = 8'h20;
  localparam logic [7:0] OP_ERS_CONF  = 8'hD0;
  localparam logic [7:0] OP_PGM_SETUP = 8'h40;
  localparam logic [7:0] OP_RD_STAT   = 8'h70;
  localparam logic [7:0] OP_CLR_STAT  = 8'h50;
  localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;

  localparam logic [7:0] STAT_READY = 8'h80;
  localparam logic [7:0] STAT_FAULT = 8'h38;

  localparam int CAUSE_TIMEOUT = 0;
  localparam int CAUSE_FAULT   = 1;
  localparam int CAUSE_VERIFY  = 2;

  function automatic logic stat_ready(input logic [7:0] s);
    return (s & STAT_READY) != 8'h00;
  endfunction

  function automatic logic stat_fault(input logic [7:0] s);
    return (s & STAT_FAULT) != 8'h00;
  endfunction

  function automatic logic [7:0] verify_expect(input logic is_prog, input logic [7:0] src);
    return is_prog ? src : 8'hFF;
  endfunction

endpackage

// File: rtl/fbs_settle_timer.sv
module fbs_settle_timer #(
  parameter int WAIT_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(WAIT_CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/fbs_poll_guard.sv
module fbs_poll_guard #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  output logic limit_hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (miss) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign limit_hit = miss && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/fbs_byte_index.sv
module fbs_byte_index #(
  parameter int DEPTH = 8192,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [IW-1:0] idx,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      idx <= '0;
    end else if (step) begin
      idx <= idx + 1'b1;
    end
  end

  assign last = (idx == IW'(DEPTH - 1));
endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
  import flash_seq_pkg::*;
#(
  parameter int BANK_BYTES     = 8192,
  parameter int BANK_SEL_W     = 1,
  parameter int SETUP_WAIT_CYC = 100,
  parameter int POLL_LIMIT     = 1000000,
  localparam int OFF_W  = $clog2(BANK_BYTES),
  localparam int ADDR_W = OFF_W + BANK_SEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_prog,
  input  logic [BANK_SEL_W-1:0] req_bank,
  output logic [OFF_W-1:0]      src_addr,
  input  logic [7:0]            src_data,
  output logic [ADDR_W-1:0]     fl_addr,
  output logic [7:0]            fl_wdata,
  output logic                  fl_we,
  output logic                  fl_re,
  input  logic [7:0]            fl_rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic [2:0]            err_cause
);

  seq_state_e state_q, state_d;

  logic [BANK_SEL_W-1:0] bank_q;
  logic                  prog_q;
  logic [2:0]            cause_q;

  logic [OFF_W-1:0] idx;
  logic             idx_last, idx_clr, idx_step;
  logic             tmr_start, tmr_expired;
  logic             poll_clr, poll_limit;
  logic [OFF_W-1:0] bus_off;

  // named internal events, observed by the bound checker
  logic evt_accept, evt_poll_ready, evt_poll_miss, evt_timeout;
  logic evt_fault, evt_clear, evt_mismatch;

  assign evt_accept     = (state_q == S_IDLE) && req_valid;
  assign evt_poll_ready = (state_q == S_POLL_EVAL) && stat_ready(fl_rdata);
  assign evt_poll_miss  = (state_q == S_POLL_EVAL) && !stat_ready(fl_rdata);
  assign evt_timeout    = evt_poll_miss && poll_limit;
  assign evt_fault      = evt_poll_ready && stat_fault(fl_rdata);
  assign evt_clear      = (state_q == S_CLR);
  assign evt_mismatch   = (state_q == S_VER_EVAL) &&
                          (fl_rdata != verify_expect(prog_q, src_data));

  fbs_settle_timer #(.WAIT_CYC(SETUP_WAIT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .expired (tmr_expired)
  );

  fbs_poll_guard #(.LIMIT(POLL_LIMIT)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (poll_clr),
    .miss      (evt_poll_miss),
    .limit_hit (poll_limit)
  );

  fbs_byte_index #(.DEPTH(BANK_BYTES)) u_index (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idx_clr),
    .step  (idx_step),
    .idx   (idx),
    .last  (idx_last)
  );

  always_comb begin
    state_d   = state_q;
    fl_we     = 1'b0;
    fl_re     = 1'b0;
    fl_wdata  = 8'h00;
    bus_off   = '0;
    tmr_start = 1'b0;
    poll_clr  = 1'b0;
    idx_clr   = 1'b0;
    idx_step  = 1'b0;
    done      = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          idx_clr = 1'b1;
          state_d = req_prog ? S_PGM_SETUP : S_ERS_SETUP;
        end
      end
      S_ERS_SETUP: begin
        fl_we    = 1'b1;
        fl_wdata = OP_ERS_SETUP;
        state_d  = S_ERS_CONF;
      end
      S_ERS_CONF: begin
        fl_we    = 1'b1;
        fl_wdata = OP_ERS_CONF;
        poll_clr = 1'b1;
        state_d  = S_POLL_CMD;
      end
      S_PGM_SETUP: begin
        fl_we     = 1'b1;
        fl_wdata  = OP_PGM_SETUP;
        bus_off   = idx;
        tmr_start = 1'b1;
        state_d   = S_PGM_WAIT;
      end
      S_PGM_WAIT: begin
        if (tmr_expired) state_d = S_PGM_DATA;
      end
      S_PGM_DATA: begin
        fl_we    = 1'b1;
        fl_wdata = src_data;
        bus_off  = idx;
        poll_clr = 1'b1;
        state_d  = S_POLL_CMD;
      end
      S_POLL_CMD: begin
        fl_we    = 1'b1;
        fl_wdata = OP_RD_STAT;
        state_d  = S_POLL_RD;
      end
      S_POLL_RD: begin
        fl_re   = 1'b1;
        state_d = S_POLL_EVAL;
      end
      S_POLL_EVAL: begin
        if (evt_poll_ready) begin
          if (prog_q && !idx_last) begin
            idx_step = 1'b1;
            state_d  = S_PGM_SETUP;
          end else begin
            state_d = S_CLR;
          end
        end else if (poll_limit) begin
          state_d = S_CLR;
        end else begin
          state_d = S_POLL_CMD;
        end
      end
      S_CLR: begin
        fl_we    = 1'b1;
        fl_wdata = OP_CLR_STAT;
        idx_clr  = 1'b1;
        state_d  = S_RST;
      end
      S_RST: begin
        fl_we    = 1'b1;
        fl_wdata = OP_RD_ARRAY;
        state_d  = S_VER_RD;
      end
      S_VER_RD: begin
        fl_re   = 1'b1;
        bus_off = idx;
        state_d = S_VER_EVAL;
      end
      S_VER_EVAL: begin
        if (evt_mismatch || idx_last) begin
          state_d = S_FINISH;
        end else begin
          idx_step = 1'b1;
          state_d  = S_VER_RD;
        end
      end
      S_FINISH: begin
        done    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      bank_q  <= '0;
      prog_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      state_q <= state_d;
      if (evt_accept) begin
        bank_q  <= req_bank;
        prog_q  <= req_prog;
        cause_q <= '0;
      end else begin
        if (evt_timeout)  cause_q[CAUSE_TIMEOUT] <= 1'b1;
        if (evt_fault)    cause_q[CAUSE_FAULT]   <= 1'b1;
        if (evt_mismatch) cause_q[CAUSE_VERIFY]  <= 1'b1;
      end
    end
  end

  assign fl_addr   = {bank_q, bus_off};
  assign src_addr  = idx;
  assign busy      = (state_q != S_IDLE);
  assign err_cause = cause_q;
  assign err       = |cause_q;

endmodule

// File: rtl/flash_bank_seq_chk.sv
module flash_bank_seq_chk #(
  parameter int BANK_SEL_W = 1,
  parameter int ADDR_W     = 14
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  done,
  input logic                  fl_we,
  input logic                  fl_re,
  input logic [7:0]            fl_wdata,
  input logic [ADDR_W-1:0]     fl_addr,
  input logic [2:0]            err_cause,
  input logic [BANK_SEL_W-1:0] bank_q,
  input logic                  evt_timeout,
  input logic                  evt_fault,
  input logic                  evt_clear,
  input logic                  evt_mismatch
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re)); // R11

  AST_BANK_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) |-> (fl_addr[ADDR_W-1 -: BANK_SEL_W] == bank_q)); // R11

  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bank_q)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R10

  AST_CLEAR_THEN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |=> (fl_we && fl_wdata == 8'hFF)); // R6

  AST_TIMEOUT_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_timeout |=> (fl_we && fl_wdata == 8'h50 && err_cause[0])); // R7

  AST_FAULT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fault |=> err_cause[1]); // R8

  AST_MISMATCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mismatch |=> (done && err_cause[2])); // R9

endmodule

bind flash_bank_seq flash_bank_seq_chk #(
  .BANK_SEL_W (BANK_SEL_W),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .fl_we        (fl_we),
  .fl_re        (fl_re),
  .fl_wdata     (fl_wdata),
  .fl_addr      (fl_addr),
  .err_cause    (err_cause),
  .bank_q       (bank_q),
  .evt_timeout  (evt_timeout),
  .evt_fault    (evt_fault),
  .evt_clear    (evt_clear),
  .evt_mismatch (evt_mismatch)
);

// File: tb/flash_bank_seq_tb.sv
module flash_bank_seq_tb;
  localparam int BB  = 16;
  localparam int BSW = 2;
  localparam int NB  = 4;
  localparam int DW  = 3;
  localparam int PL  = 8;
  localparam int OW  = 4;
  localparam int AW  = 6;
  localparam int MS  = NB * BB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_prog = 1'b0;
  logic [BSW-1:0] req_bank = '0;
  logic [OW-1:0] src_addr;
  logic [7:0]    src_data;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic          fl_we, fl_re;
  logic [7:0]    fl_rdata = 8'h00;
  logic          busy, done, err;
  logic [2:0]    err_cause;

  always #5 clk = ~clk;

  flash_bank_seq #(
    .BANK_BYTES(BB), .BANK_SEL_W(BSW), .SETUP_WAIT_CYC(DW), .POLL_LIMIT(PL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prog(req_prog),
    .req_bank(req_bank), .src_addr(src_addr), .src_data(src_data),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata), .busy(busy), .done(done), .err(err),
    .err_cause(err_cause)
  );

  // knobs, written only by the stimulus process
  int        cur_seed = 0;
  int        cur_bank = 0;
  int        lat = 1;
  bit        stuck = 0;
  logic [7:0] inj_err = 8'h00;
  int        corrupt_idx = -1;
  int        prefill_tok = 0;

  function automatic logic [7:0] src_byte(input int seed, input int i);
    if (seed == 0) return 8'h00;
    if (seed == 1) return i[0] ? 8'hAA : 8'h55;
    return 8'(seed * 29 + i * 71) ^ 8'(i << 3);
  endfunction

  function automatic logic [7:0] fill_byte(input int tok, input int i);
    return 8'(i * 7 + 3 + tok * 11);
  endfunction

  assign src_data = src_byte(cur_seed, int'(src_addr));

  // behavioural flash model, written only by this process
  typedef enum int {M_ARRAY, M_STATUS, M_PSET, M_ESET} mmode_e;
  logic [7:0] mem [0:MS-1];
  mmode_e     mode = M_ARRAY;
  logic [7:0] stat_bits = 8'h00;
  int busy_cnt = 0, cyc = 0, pset_cyc = 0, prefill_done = 0;
  int n_prog = 0, n_erase = 0, n_vreads = 0, n_resets = 0, viol = 0, n_done = 0;
  bit last_clear = 0;

  always @(posedge clk) begin
    logic [7:0] rd;
    bit was_clear;
    cyc++;
    if (prefill_tok != prefill_done) begin
      for (int i = 0; i < MS; i++) mem[i] = fill_byte(prefill_tok, i);
      prefill_done = prefill_tok;
    end
    if (!rst_n) begin
      mode = M_ARRAY;
      busy_cnt = 0;
    end else begin
      if (fl_re) begin
        if (int'(fl_addr[AW-1:OW]) != cur_bank) viol++;
        if (mode == M_STATUS) begin
          if (fl_addr[OW-1:0] != 0) viol++;
          rd = stat_bits;
          if (busy_cnt == 0 && !stuck) rd = rd | 8'h80;
          fl_rdata <= rd;
        end else if (mode == M_ARRAY) begin
          fl_rdata <= mem[fl_addr];
          n_vreads++;
        end else viol++;
      end
      if (fl_we) begin
        if (int'(fl_addr[AW-1:OW]) != cur_bank) viol++;
        was_clear = last_clear;
        last_clear = 0;
        if (mode == M_PSET) begin
          if (cyc - pset_cyc <= DW) viol++;
          mem[fl_addr] = (int'(fl_addr[OW-1:0]) == corrupt_idx) ? (fl_wdata ^ 8'h01) : fl_wdata;
          n_prog++;
          busy_cnt = lat;
          stat_bits = inj_err;
          mode = M_STATUS;
        end else if (mode == M_ESET) begin
          if (fl_wdata != 8'hD0 || fl_addr[OW-1:0] != 0) viol++;
          else begin
            for (int j = 0; j < BB; j++)
              mem[cur_bank * BB + j] = (j == corrupt_idx) ? 8'h7F : 8'hFF;
            n_erase++;
            busy_cnt = lat;
            stat_bits = inj_err;
          end
          mode = M_STATUS;
        end else begin
          case (fl_wdata)
            8'h40: begin mode = M_PSET; pset_cyc = cyc; end
            8'h20: begin if (fl_addr[OW-1:0] != 0) viol++; mode = M_ESET; end
            8'h70: begin if (fl_addr[OW-1:0] != 0) viol++; mode = M_STATUS; end
            8'h50: begin if (fl_addr[OW-1:0] != 0) viol++; stat_bits = 8'h00; last_clear = 1; end
            8'hFF: begin
              if (!was_clear || fl_addr[OW-1:0] != 0) viol++;
              else n_resets++;
              mode = M_ARRAY;
            end
            default: viol++;
          endcase
        end
      end
      if (busy_cnt > 0) busy_cnt--;
      if (done) n_done++;
    end
  end

  int checks = 0, errors = 0;
  logic [2:0] got_cause;
  logic got_err;
  int d_prog, d_erase, d_vreads, d_resets, d_viol, d_done;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prefill();
    prefill_tok++;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input bit prog, input int bank, input int seed, input int latency,
                        input bit stk, input logic [7:0] inj, input int cidx);
    int p0, e0, v0, r0, x0, q0;
    bit seen;
    cur_bank = bank; cur_seed = seed; lat = latency; stuck = stk;
    inj_err = inj; corrupt_idx = cidx;
    p0 = n_prog; e0 = n_erase; v0 = n_vreads; r0 = n_resets; x0 = viol; q0 = n_done;
    @(negedge clk);
    req_valid = 1'b1; req_prog = prog; req_bank = BSW'(bank);
    @(negedge clk);
    req_valid = 1'b0;
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    chk("R10 done seen", int'(seen), 1);
    got_cause = err_cause;
    got_err = err;
    @(negedge clk);
    chk("R10 done single cycle", int'(done), 0);
    chk("R10 err equals cause OR", int'(got_err), int'(|got_cause));
    d_prog = n_prog - p0; d_erase = n_erase - e0; d_vreads = n_vreads - v0;
    d_resets = n_resets - r0; d_viol = viol - x0; d_done = n_done - q0;
  endtask

  function automatic int bank_vs_src(input int bank, input int seed);
    int n = 0;
    for (int i = 0; i < BB; i++) if (mem[bank * BB + i] != src_byte(seed, i)) n++;
    return n;
  endfunction

  function automatic int bank_vs_ff(input int bank);
    int n = 0;
    for (int i = 0; i < BB; i++) if (mem[bank * BB + i] != 8'hFF) n++;
    return n;
  endfunction

  function automatic int others_vs_fill(input int bank, input int tok);
    int n = 0;
    for (int i = 0; i < MS; i++) if (i / BB != bank && mem[i] != fill_byte(tok, i)) n++;
    return n;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 strobes after reset", int'(fl_we | fl_re), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle busy", int'(busy), 0);
    chk("R1 idle done", int'(done), 0);
    chk("R1 idle err", int'(err), 0);
    chk("R1 idle cause", int'(err_cause), 0);
    chk("R1 idle strobes", int'(fl_we | fl_re), 0);

    // erase sweep over every bank
    for (int b = 0; b < NB; b++) begin
      prefill();
      run_op(1'b0, b, 0, b + 1, 1'b0, 8'h00, -1);
      chk("R3 erase cause", int'(got_cause), 0);
      chk("R3 erase count", d_erase, 1);
      chk("R3 R4 R6 protocol", d_viol, 0);
      chk("R6 reset issued", d_resets, 1);
      chk("R9 bank erased", bank_vs_ff(b), 0);
      chk("R9 erase verify reads", d_vreads, BB);
      chk("R11 other banks kept", others_vs_fill(b, prefill_tok), 0);
    end

    // program sweep: every bank, three patterns, varied latency
    for (int b = 0; b < NB; b++) begin
      for (int s = 0; s < 3; s++) begin
        prefill();
        run_op(1'b1, b, s, (b + s) % 5 + 1, 1'b0, 8'h00, -1);
        chk("R5 program cause", int'(got_cause), 0);
        chk("R5 bytes programmed", d_prog, BB);
        chk("R5 R4 R6 protocol", d_viol, 0);
        chk("R5 bank contents", bank_vs_src(b, s), 0);
        chk("R9 program verify reads", d_vreads, BB);
        chk("R11 other banks kept", others_vs_fill(b, prefill_tok), 0);
      end
    end

    // timeout during program: abort after first byte
    prefill();
    run_op(1'b1, 2, 2, 1, 1'b1, 8'h00, -1);
    chk("R7 program timeout bit", int'(got_cause[0]), 1);
    chk("R7 abort remaining bytes", d_prog, 1);
    chk("R7 clear and reset after timeout", d_resets, 1);
    chk("R7 protocol", d_viol, 0);

    // timeout during erase
    prefill();
    run_op(1'b0, 1, 0, 1, 1'b1, 8'h00, -1);
    chk("R7 erase timeout bit", int'(got_cause[0]), 1);
    chk("R7 erase single command", d_erase, 1);

    // device fault with good data
    prefill();
    run_op(1'b1, 3, 2, 2, 1'b0, 8'h10, -1);
    chk("R8 program fault only", int'(got_cause), 2);
    chk("R8 data still good", bank_vs_src(3, 2), 0);
    prefill();
    run_op(1'b0, 0, 0, 2, 1'b0, 8'h20, -1);
    chk("R8 erase fault only", int'(got_cause), 2);

    // verify mismatch in the middle and on the last byte
    prefill();
    run_op(1'b1, 0, 2, 1, 1'b0, 8'h00, 9);
    chk("R9 program mismatch cause", int'(got_cause), 4);
    chk("R9 verify stops at first mismatch", d_vreads, 10);
    prefill();
    run_op(1'b0, 2, 0, 1, 1'b0, 8'h00, BB - 1);
    chk("R9 erase mismatch cause", int'(got_cause), 4);
    chk("R9 erase mismatch on last byte", d_vreads, BB);

    // request held while busy is ignored
    prefill();
    cur_bank = 1; cur_seed = 1; lat = 2; stuck = 0; inj_err = 8'h00; corrupt_idx = -1;
    begin
      int q0, x0;
      bit seen;
      q0 = n_done; x0 = viol;
      @(negedge clk);
      req_valid = 1'b1; req_prog = 1'b1; req_bank = 2'd1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) @(negedge clk);
      req_valid = 1'b1; req_prog = 1'b0; req_bank = 2'd3;
      repeat (12) @(negedge clk);
      req_valid = 1'b0;
      seen = 0;
      for (int i = 0; i < 5000 && !seen; i++) begin
        if (done) seen = 1;
        else @(negedge clk);
      end
      chk("R2 done seen", int'(seen), 1);
      chk("R2 kept program kind", int'(err_cause), 0);
      repeat (10) @(negedge clk);
      chk("R2 one completion only", n_done - q0, 1);
      chk("R2 no stray bus access", viol - x0, 0);
      chk("R2 target bank written", bank_vs_src(1, 1), 0);
      chk("R2 other banks kept", others_vs_fill(1, prefill_tok), 0);
      chk("R10 idle afterwards", int'(busy), 0);
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule